// File: doc/BRIEF.md
# UART Register Front End

This block is the software-facing side of a simple serial port. A processor reaches it over a 32-bit register bus that accepts whole-word accesses only. Writing the transmit register hands one byte to a downstream serializer over a valid/ready byte stream. Bytes arriving from the deserializer land in an 8-entry receive queue, which software drains by reading the receive register.

Two threshold fields decide the interrupt-pending bits. The transmit threshold sits in the transmit control word and the receive threshold in the receive control word. The pending bits are computed live from state each time they are read, so they are never latched. The single level interrupt line follows a separate rule that is qualified by the enable register. The baud divisor word is stored and read back only; bit timing and shifting are done elsewhere.

Register offsets (byte addresses) are: divisor 0x00, transmit control 0x04, receive control 0x08, interrupt enable 0x0C, interrupt pending 0x10, transmit data 0x14 and receive data 0x18. Read data is combinational in the cycle the access is presented, and side effects take place at the next rising clock edge.

Top module: `uart_reg_front`

## Requirements
- R1: An access is valid only when `busByteEn` is 4'hF and `busAddr[1:0]` is 0. Any other access reads 0, writes nothing and pops nothing.
- R2: The divisor (0x00), transmit control (0x04), receive control (0x08) and interrupt enable (0x0C) words keep all 32 written bits and return them on read.
- R3: Reading transmit data (0x14) returns 0. Writing it places bits 7:0 of the word on `txData` with `txValid` high from the next cycle until a cycle with `txReady` high.
- R4: A transmit-data write that arrives while a byte is held with `txValid` high and `txReady` low is dropped, and the held byte stays unchanged.
- R5: Reading receive data (0x18) with the queue not empty returns the oldest byte in bits 7:0, zero-extended, and removes it. Bytes come out in arrival order.
- R6: Reading receive data with the queue empty returns 32'h8000_0000 and changes no state.
- R7: `rxReady` is low exactly when the queue holds 8 bytes. A byte offered with `rxValid` while the queue is full is discarded.
- R8: Pending bit 0 (0x10) is 1 when bits 18:16 of transmit control are nonzero.
- R9: Pending bit 1 is 1 when the queue occupancy is strictly greater than bits 18:16 of receive control. All other pending bits read 0.
- R10: Writes to the pending register (0x10) have no effect.
- R11: `irq` is high when enable bit 0 is set, or when enable bit 1 is set and the queue is not empty.
- R12: Accesses to undecoded offsets (0x1C) read 0 and ignore writes.
- R13: After reset all stored words are 0, the queue is empty, `txValid` is low and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| busSel | input | 1 | Register access presented this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte address of the access |
| busByteEn | input | 4 | Byte enables; must be all ones |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the access cycle |
| txValid | output | 1 | Transmit byte available |
| txData | output | 8 | Transmit byte |
| txReady | input | 1 | Serializer takes the byte |
| rxValid | input | 1 | Incoming byte offered |
| rxByte | input | 8 | Incoming byte |
| rxReady | output | 1 | Queue can accept a byte |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that the serializer and deserializer follow the stream rules. A byte offered on `rxValid` counts only in a cycle where `rxReady` is high. `txReady` may go high at any time, and the held transmit byte must stay stable until it does. The bench drives every input at the falling clock edge and holds `rxValid` for exactly one cycle per byte, including the deliberate offer made while the queue is full. It also toggles `txReady` only between transfers, so a stalled byte is observed across several cycles before it is released.

// File: rtl/uart_regs_pkg.sv
package uart_regs_pkg;
  localparam int BUS_W  = 32;
  localparam int WM_LSB = 16;
  localparam int WM_W   = 3;

  localparam int OFF_DIV = 'h00;
  localparam int OFF_TXC = 'h04;
  localparam int OFF_RXC = 'h08;
  localparam int OFF_IE  = 'h0C;
  localparam int OFF_IP  = 'h10;
  localparam int OFF_TXD = 'h14;
  localparam int OFF_RXD = 'h18;

  localparam logic [BUS_W-1:0] RX_EMPTY_WORD = 32'h8000_0000;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_DIV, SEL_TXC, SEL_RXC, SEL_IE, SEL_IP, SEL_TXD, SEL_RXD
  } regSel_e;

  typedef struct packed {
    logic    wrDiv;
    logic    wrTxCtrl;
    logic    wrRxCtrl;
    logic    wrIntEn;
    logic    wrTxData;
    logic    popRx;
    regSel_e rdSel;
  } strobes_t;
endpackage

// File: rtl/uart_reg_ctrl.sv
module uart_reg_ctrl
  import uart_regs_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [3:0]        busByteEn,
  output strobes_t          strobes
);
  logic    wordOk;
  logic    doWrite;
  logic    doRead;
  regSel_e hitSel;

  assign wordOk  = busSel && (&busByteEn) && (busAddr[1:0] == 2'b00);
  assign doWrite = wordOk && busWrite;
  assign doRead  = wordOk && !busWrite;

  always_comb begin
    if      (busAddr == ADDR_W'(OFF_DIV)) hitSel = SEL_DIV;
    else if (busAddr == ADDR_W'(OFF_TXC)) hitSel = SEL_TXC;
    else if (busAddr == ADDR_W'(OFF_RXC)) hitSel = SEL_RXC;
    else if (busAddr == ADDR_W'(OFF_IE))  hitSel = SEL_IE;
    else if (busAddr == ADDR_W'(OFF_IP))  hitSel = SEL_IP;
    else if (busAddr == ADDR_W'(OFF_TXD)) hitSel = SEL_TXD;
    else if (busAddr == ADDR_W'(OFF_RXD)) hitSel = SEL_RXD;
    else                                  hitSel = SEL_NONE;
  end

  always_comb begin
    strobes          = '0;
    strobes.rdSel    = doRead ? hitSel : SEL_NONE;
    strobes.popRx    = doRead  && (hitSel == SEL_RXD);
    strobes.wrDiv    = doWrite && (hitSel == SEL_DIV);
    strobes.wrTxCtrl = doWrite && (hitSel == SEL_TXC);
    strobes.wrRxCtrl = doWrite && (hitSel == SEL_RXC);
    strobes.wrIntEn  = doWrite && (hitSel == SEL_IE);
    strobes.wrTxData = doWrite && (hitSel == SEL_TXD);
  end
endmodule

// File: rtl/uart_reg_datapath.sv
module uart_reg_datapath
  import uart_regs_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobes_t         strobes,
  input  logic [BUS_W-1:0] busWdata,
  output logic [BUS_W-1:0] busRdata,
  output logic             txValid,
  output logic [7:0]       txData,
  input  logic             txReady,
  input  logic             rxValid,
  input  logic [7:0]       rxByte,
  output logic             rxReady,
  output logic             irq
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [BUS_W-1:0] divReg, txCtrl, rxCtrl, intEn;
  logic [7:0]       fifoMem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] rxCount;
  logic             push, pop, txLoad;
  logic             txWmHit, rxWmHit;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divReg <= '0;
      txCtrl <= '0;
      rxCtrl <= '0;
      intEn  <= '0;
    end else begin
      if (strobes.wrDiv)    divReg <= busWdata;
      if (strobes.wrTxCtrl) txCtrl <= busWdata;
      if (strobes.wrRxCtrl) rxCtrl <= busWdata;
      if (strobes.wrIntEn)  intEn  <= busWdata;
    end
  end

  assign txLoad = strobes.wrTxData && (!txValid || txReady);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txValid <= 1'b0;
      txData  <= '0;
    end else if (txLoad) begin
      txValid <= 1'b1;
      txData  <= busWdata[7:0];
    end else if (txReady) begin
      txValid <= 1'b0;
    end
  end

  assign rxReady = (rxCount != FULL_CNT);
  assign push    = rxValid && rxReady;
  assign pop     = strobes.popRx && (rxCount != '0);

  always_ff @(posedge clk) begin
    if (push) fifoMem[wrPtr] <= rxByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      rxCount <= '0;
    end else begin
      if (push) wrPtr <= nextPtr(wrPtr);
      if (pop)  rdPtr <= nextPtr(rdPtr);
      case ({push, pop})
        2'b10:   rxCount <= rxCount + 1'b1;
        2'b01:   rxCount <= rxCount - 1'b1;
        default: rxCount <= rxCount;
      endcase
    end
  end

  assign txWmHit = (txCtrl[WM_LSB +: WM_W] != '0);
  assign rxWmHit = (32'(rxCount) > 32'(rxCtrl[WM_LSB +: WM_W]));
  assign irq     = intEn[0] || (intEn[1] && (rxCount != '0));

  always_comb begin
    case (strobes.rdSel)
      SEL_DIV: busRdata = divReg;
      SEL_TXC: busRdata = txCtrl;
      SEL_RXC: busRdata = rxCtrl;
      SEL_IE:  busRdata = intEn;
      SEL_IP:  busRdata = {{(BUS_W-2){1'b0}}, rxWmHit, txWmHit};
      SEL_RXD: busRdata = (rxCount != '0) ? {{(BUS_W-8){1'b0}}, fifoMem[rdPtr]}
                                          : RX_EMPTY_WORD;
      default: busRdata = '0;
    endcase
  end

  // R7
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxCount <= FULL_CNT);

  // R7
  full_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !rxReady && !strobes.popRx) |=> $stable(rxCount));

  // R6
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.popRx && rxCount == '0 && !rxValid) |=> (rxCount == '0) && $stable(rdPtr));

  // R5
  pop_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.popRx && rxCount != '0 && !rxValid) |=> rxCount == $past(rxCount) - 1'b1);

  // R4
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> txValid && $stable(txData));
endmodule

// File: rtl/uart_reg_front.sv
module uart_reg_front
  import uart_regs_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int RX_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [3:0]        busByteEn,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              txValid,
  output logic [7:0]        txData,
  input  logic              txReady,
  input  logic              rxValid,
  input  logic [7:0]        rxByte,
  output logic              rxReady,
  output logic              irq
);
  strobes_t strobes;

  uart_reg_ctrl #(.ADDR_W(ADDR_W)) ctrl (
    .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
    .busByteEn(busByteEn), .strobes(strobes)
  );

  uart_reg_datapath #(.DEPTH(RX_DEPTH)) dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .busWdata(busWdata),
    .busRdata(busRdata), .txValid(txValid), .txData(txData), .txReady(txReady),
    .rxValid(rxValid), .rxByte(rxByte), .rxReady(rxReady), .irq(irq)
  );

  // R1
  bad_access_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !(&busByteEn)) |-> busRdata == '0);
endmodule

// File: tb/uart_reg_front_test.sv
module uart_reg_front_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWrite = 1'b0;
  logic [4:0]  busAddr = '0;
  logic [3:0]  busByteEn = '0;
  logic [31:0] busWdata = '0, busRdata;
  logic        txValid, txReady = 1'b0;
  logic [7:0]  txData;
  logic        rxValid = 1'b0, rxReady, irq;
  logic [7:0]  rxByte = '0;

  int checks = 0, fails = 0;
  logic [7:0] expectQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_reg_front uut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busByteEn(busByteEn), .busWdata(busWdata),
    .busRdata(busRdata), .txValid(txValid), .txData(txData), .txReady(txReady),
    .rxValid(rxValid), .rxByte(rxByte), .rxReady(rxReady), .irq(irq)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expectEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    check(act === exp, tag, act, exp);
  endtask

  task automatic busAccess(input bit wr, input logic [4:0] a, input logic [31:0] d,
                           input logic [3:0] be, output logic [31:0] rd);
    @(negedge clk);
    busSel = 1'b1; busWrite = wr; busAddr = a; busWdata = d; busByteEn = be;
    #1 rd = busRdata;
    @(posedge clk);
    #1 busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic busWr(input logic [4:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
    logic [31:0] unused;
    busAccess(1'b1, a, d, be, unused);
  endtask

  task automatic busRd(input logic [4:0] a, output logic [31:0] rd, input logic [3:0] be = 4'hF);
    busAccess(1'b0, a, 32'h0, be, rd);
  endtask

  task automatic txPush(input logic [31:0] w);
    expectQ.push_back(w[7:0]);
    busWr(5'h14, w);
  endtask

  task automatic rxSend(input logic [7:0] b);
    @(negedge clk);
    rxValid = 1'b1; rxByte = b;
    @(posedge clk);
    #1 rxValid = 1'b0;
  endtask

  task automatic finishUp;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // Scoreboard monitor: handshake decided by values stable after the falling edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rstN && txValid && txReady) begin
        if (expectQ.size() == 0) check(1'b0, "R3 unexpected tx byte", {24'h0, txData}, 32'h0);
        else expectEq("R3 tx byte", {24'h0, txData}, {24'h0, expectQ.pop_front()});
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    check(1'b0, "watchdog", 32'h0, 32'h1);
    finishUp();
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R13 reset state
    busRd(5'h00, rd); expectEq("R13 divisor", rd, 32'h0);
    busRd(5'h0C, rd); expectEq("R13 enable", rd, 32'h0);
    expectEq("R13 irq", {31'h0, irq}, 32'h0);
    expectEq("R13 txValid", {31'h0, txValid}, 32'h0);
    expectEq("R13 rxReady", {31'h0, rxReady}, 32'h1);

    // R2 store and read back
    busWr(5'h00, 32'hDEAD_BEEF); busRd(5'h00, rd); expectEq("R2 divisor", rd, 32'hDEAD_BEEF);
    busWr(5'h08, 32'h5A5A_0001); busRd(5'h08, rd); expectEq("R2 rx control", rd, 32'h5A5A_0001);

    // R1 partial and misaligned accesses ignored
    busWr(5'h00, 32'h0, 4'h3);   busRd(5'h00, rd); expectEq("R1 partial write", rd, 32'hDEAD_BEEF);
    busWr(5'h01, 32'h0);         busRd(5'h00, rd); expectEq("R1 misaligned write", rd, 32'hDEAD_BEEF);
    busRd(5'h00, rd, 4'h7);      expectEq("R1 partial read", rd, 32'h0);

    // R12 undecoded offset
    busWr(5'h1C, 32'hFFFF_FFFF); busRd(5'h1C, rd); expectEq("R12 hole read", rd, 32'h0);
    busRd(5'h00, rd); expectEq("R12 hole write", rd, 32'hDEAD_BEEF);

    // R8 transmit threshold pending bit; R10 pending not writable
    busWr(5'h08, 32'h0);
    busWr(5'h04, 32'h0002_0000); busRd(5'h10, rd); expectEq("R8 tx pending set", rd, 32'h1);
    busWr(5'h04, 32'h0000_FFFF); busRd(5'h10, rd); expectEq("R8 tx pending clear", rd, 32'h0);
    busRd(5'h04, rd); expectEq("R2 tx control", rd, 32'h0000_FFFF);
    busWr(5'h10, 32'hFFFF_FFFF); busRd(5'h10, rd); expectEq("R10 pending write", rd, 32'h0);

    // R11 enable bit 0 alone drives irq
    busWr(5'h0C, 32'h1); #1 expectEq("R11 irq tx enable", {31'h0, irq}, 32'h1);
    busWr(5'h0C, 32'h0); #1 expectEq("R11 irq off", {31'h0, irq}, 32'h0);

    // R3 / R4 transmit path with a stalled sink
    txPush(32'h1234_5677);
    busWr(5'h14, 32'h0000_003C); // R4 dropped, not queued
    expectEq("R3 txValid", {31'h0, txValid}, 32'h1);
    expectEq("R4 held byte", {24'h0, txData}, 32'h77);
    busRd(5'h14, rd); expectEq("R3 tx read zero", rd, 32'h0);
    @(negedge clk) txReady = 1'b1;
    repeat (2) @(posedge clk);
    txPush(32'h0000_00AB);
    txPush(32'hFFFF_FFC3);
    repeat (4) @(posedge clk);
    #3;
    expectEq("R4 queue drained", expectQ.size(), 32'h0);
    expectEq("R3 txValid low", {31'h0, txValid}, 32'h0);

    // R9 / R11 / R7 / R5 / R6 receive path
    busWr(5'h08, 32'h0003_0000);
    busWr(5'h0C, 32'h2);
    #1 expectEq("R11 irq empty", {31'h0, irq}, 32'h0);
    for (int i = 0; i < 3; i++) rxSend(8'h10 + 8'(i));
    busRd(5'h10, rd); expectEq("R9 at threshold", rd, 32'h0);
    expectEq("R11 irq rx", {31'h0, irq}, 32'h1);
    rxSend(8'h13);
    busRd(5'h10, rd); expectEq("R9 above threshold", rd, 32'h2);
    for (int i = 4; i < 8; i++) rxSend(8'h10 + 8'(i));
    expectEq("R7 rxReady full", {31'h0, rxReady}, 32'h0);
    rxSend(8'hEE); // R7 dropped
    busRd(5'h18, rd, 4'h7); expectEq("R1 partial rx read", rd, 32'h0);
    for (int i = 0; i < 8; i++) begin
      busRd(5'h18, rd);
      expectEq("R5 rx order", rd, 32'h10 + 32'(i));
    end
    #1 expectEq("R11 irq drained", {31'h0, irq}, 32'h0);
    busRd(5'h18, rd); expectEq("R6 empty read", rd, 32'h8000_0000);
    busRd(5'h18, rd); expectEq("R6 empty again", rd, 32'h8000_0000);
    expectEq("R7 rxReady again", {31'h0, rxReady}, 32'h1);
    rxSend(8'h5C);
    busRd(5'h18, rd); expectEq("R5 after empty reads", rd, 32'h5C);

    finishUp();
  end
endmodule